// File: doc/BRIEF.md
# Branch Record Ring Buffer

This block keeps a short history of taken branches. Each cycle a branch event may arrive with its source address, its target address, a branch class, whether its target runs at ring 0, and three status flags (mispredicted, inside a transaction, transaction abort). An event that survives filtering is stored as a pair of 64-bit words in a circular buffer of `DEPTH` slots, and a top-of-stack pointer always names the slot written last.

Filtering is done by a select register that works by exclusion. One bit per branch class and one bit per target privilege level each veto capture when set. The three flags are packed into the upper bits of the stored source word, and the address sits sign-extended below them. A control register turns recording on and can arm a freeze. When armed, a performance-monitor interrupt pulse stops recording until software clears the frozen status. A combinational read port returns entries newest-first by index. A small register window gives software access to the select, control, pointer and status registers and to a clear command.

Top module: `branch_record_ring`

## Requirements
- R1: After reset the pointer, select, control and status registers read 0, and every entry reads 0 on both words.
- R2: A recorded branch advances the pointer by one, modulo `DEPTH`, and in that same clock edge writes the slot the pointer moves to. Read index 0 shows the new entry from the next cycle on.
- R3: Read index i returns physical slot (pointer − i) mod `DEPTH`, so entries come out newest first. Older entries are overwritten once the buffer wraps.
- R4: Source word layout: bit 63 is mispredict, bit 62 is in-transaction, bit 61 is abort, and bits 60:0 hold the source address sign-extended from `VA_W` bits. The target word is the target address sign-extended to 64 bits.
- R5: Class codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump and 6 far. Select bit (2 + class) set suppresses that class: the pointer and the entries stay unchanged. Class code 7 has no class veto.
- R6: Select bit 0 suppresses branches whose target is ring 0 (`br_tgt_ring0`=1). Select bit 1 suppresses branches whose target is any other ring.
- R7: Nothing is recorded while control bit 0 (record enable) is 0.
- R8: With control bit 1 (freeze on interrupt) set, a `pmi` pulse sets status bit 0 on the next edge, and recording stops from then on. A branch in the same cycle as the pulse is still recorded.
- R9: Writing 1 to status bit 0 clears the frozen state and re-arms recording. Writing 0 leaves it unchanged. A `pmi` pulse with control bit 1 clear does not freeze. If a pulse and a clear arrive in the same cycle, the pulse wins.
- R10: A write to the pointer register loads its low bits into the pointer. A branch in the same cycle is dropped.
- R11: A write to the clear address zeroes every source and target word and leaves the pointer as it is. A branch in the same cycle is dropped.
- R12: The select register holds 9 bits. Its upper bits, and the upper bits of control, pointer and status, read 0. Register addresses: 0 select, 1 control, 2 pointer, 3 status, 4 clear. The clear address and any unused address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch event this cycle |
| br_class | input | 3 | Branch class code |
| br_tgt_ring0 | input | 1 | Branch target runs at ring 0 |
| br_from | input | VA_W | Source address |
| br_to | input | VA_W | Target address |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch inside a transaction |
| br_abort | input | 1 | Branch is a transaction abort |
| pmi | input | 1 | Performance-monitor interrupt pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| rd_idx | input | log2(DEPTH) | Entry index, 0 = newest |
| rd_from | output | 64 | Source word at `rd_idx` |
| rd_to | output | 64 | Target word at `rd_idx` |

## Verification
The hardest situations to reach are cycles where several agents act on the same edge. Examples are an interrupt pulse together with a branch, a status clear together with a pulse, and a pointer write or clear command together with a branch. Directed steps force each of these collisions on purpose. A long random stretch then mixes branch events, interrupt pulses and register writes to all addresses at the same time. A behavioural model checks the full entry array and every register after each edge, so a wrap of the pointer past a software-loaded value is also checked against the model.

// File: rtl/brr_pkg.sv
`timescale 1ns/1ps
package brr_pkg;

    localparam int WORD_W     = 64;
    localparam int SEL_W      = 9;
    localparam int NUM_CLS    = 7;
    localparam int RING0_BIT  = 0;
    localparam int RINGN_BIT  = 1;
    localparam int CLASS_BASE = 2;
    localparam int ADDR_KEEP  = 61;

    localparam logic [2:0] RA_SELECT = 3'd0;
    localparam logic [2:0] RA_CTRL   = 3'd1;
    localparam logic [2:0] RA_TOS    = 3'd2;
    localparam logic [2:0] RA_STATUS = 3'd3;
    localparam logic [2:0] RA_CLEAR  = 3'd4;

    typedef enum logic [2:0] {
        BR_COND     = 3'd0,
        BR_REL_CALL = 3'd1,
        BR_IND_CALL = 3'd2,
        BR_NEAR_RET = 3'd3,
        BR_IND_JMP  = 3'd4,
        BR_REL_JMP  = 3'd5,
        BR_FAR      = 3'd6,
        BR_OTHER    = 3'd7
    } br_class_e;

    typedef struct packed {
        logic freeze_on_pmi;
        logic rec_en;
    } ctrl_t;

endpackage

// File: rtl/brr_filter.sv
`timescale 1ns/1ps
module brr_filter
    import brr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [2:0]       cls,
    input  logic             tgt_ring0,
    output logic             suppress
);

    logic [NUM_CLS-1:0] cls_hit;
    logic               ring_hit;

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
        assign cls_hit[g] = sel[CLASS_BASE+g] && (cls == 3'(g));
    end

    assign ring_hit = tgt_ring0 ? sel[RING0_BIT] : sel[RINGN_BIT];
    assign suppress = (|cls_hit) || ring_hit;

endmodule

// File: rtl/brr_ctrl.sv
`timescale 1ns/1ps
module brr_ctrl
    import brr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              pmi,
    input  logic              br_valid,
    input  logic              suppress,
    output logic [SEL_W-1:0]  sel,
    output logic [IDX_W-1:0]  tos,
    output logic              rec,
    output logic              clr,
    output logic [WORD_W-1:0] reg_rdata
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        ctrl_t            ctl;
        logic [IDX_W-1:0] tos;
        logic             frozen;
    } state_t;

    state_t s_d, s_q;

    logic wr_sel_d, wr_ctl_d, wr_tos_d, wr_sts_d, wr_clr_d;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[WORD_W-1:SEL_W];

    always_comb begin
        wr_sel_d = reg_wr && (reg_addr == RA_SELECT);
        wr_ctl_d = reg_wr && (reg_addr == RA_CTRL);
        wr_tos_d = reg_wr && (reg_addr == RA_TOS);
        wr_sts_d = reg_wr && (reg_addr == RA_STATUS);
        wr_clr_d = reg_wr && (reg_addr == RA_CLEAR);

        rec = br_valid && s_q.ctl.rec_en && !s_q.frozen && !suppress
              && !wr_tos_d && !wr_clr_d;
        clr = wr_clr_d;

        s_d = s_q;
        if (wr_sel_d) s_d.sel = reg_wdata[SEL_W-1:0];
        if (wr_ctl_d) s_d.ctl = ctrl_t'(reg_wdata[1:0]);
        if (wr_tos_d)  s_d.tos = reg_wdata[IDX_W-1:0];
        else if (rec)  s_d.tos = s_q.tos + 1'b1;
        if (wr_sts_d && reg_wdata[0]) s_d.frozen = 1'b0;
        if (pmi && s_q.ctl.freeze_on_pmi) s_d.frozen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel = s_q.sel;
    assign tos = s_q.tos;

    always_comb begin
        unique case (reg_addr)
            RA_SELECT: reg_rdata = WORD_W'(s_q.sel);
            RA_CTRL:   reg_rdata = WORD_W'(s_q.ctl);
            RA_TOS:    reg_rdata = WORD_W'(s_q.tos);
            RA_STATUS: reg_rdata = WORD_W'(s_q.frozen);
            default:   reg_rdata = '0;
        endcase
    end

    // R2: a recorded branch moves the pointer by exactly one
    a_r2_tos_step: assert property (@(posedge clk) disable iff (!rst_n)
        rec |=> tos == IDX_W'($past(tos) + 1'b1));

    // R10: software pointer load lands on the next edge
    a_r10_sw_tos: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_TOS) |=> tos == $past(reg_wdata[IDX_W-1:0]));

    // R5: without a record or a pointer write the pointer holds
    a_r5_tos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec && !(reg_wr && reg_addr == RA_TOS)) |=> $stable(tos));

    // R8: armed interrupt freezes
    a_r8_freeze_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi && s_q.ctl.freeze_on_pmi) |=> s_q.frozen);

    // R9: frozen persists until a write of 1 to the status bit
    a_r9_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.frozen && !(reg_wr && reg_addr == RA_STATUS && reg_wdata[0])) |=> s_q.frozen);

    // R8: no recording while frozen
    a_r8_no_rec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.frozen |-> !rec);

endmodule

// File: rtl/brr_store.sv
`timescale 1ns/1ps
module brr_store
    import brr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              clr,
    input  logic [IDX_W-1:0]  tos,
    input  logic [WORD_W-1:0] wr_from,
    input  logic [WORD_W-1:0] wr_to,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_from,
    output logic [WORD_W-1:0] rd_to
);

    logic [WORD_W-1:0] from_q [DEPTH];
    logic [WORD_W-1:0] from_d [DEPTH];
    logic [WORD_W-1:0] to_q   [DEPTH];
    logic [WORD_W-1:0] to_d   [DEPTH];
    logic [IDX_W-1:0]  wr_slot_d;
    logic [IDX_W-1:0]  rd_slot_d;

    assign wr_slot_d = tos + 1'b1;
    assign rd_slot_d = tos - rd_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            from_d[i] = from_q[i];
            to_d[i]   = to_q[i];
            if (clr) begin
                from_d[i] = '0;
                to_d[i]   = '0;
            end else if (wr_en && (wr_slot_d == IDX_W'(i))) begin
                from_d[i] = wr_from;
                to_d[i]   = wr_to;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                from_q[i] <= '0;
                to_q[i]   <= '0;
            end
        end else begin
            from_q <= from_d;
            to_q   <= to_d;
        end
    end

    assign rd_from = from_q[rd_slot_d];
    assign rd_to   = to_q[rd_slot_d];

    // R11: clear wipes the slots
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (from_q[0] == '0 && to_q[0] == '0 && from_q[DEPTH-1] == '0));

endmodule

// File: rtl/branch_record_ring.sv
`timescale 1ns/1ps
module branch_record_ring
    import brr_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int VA_W  = 48,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [2:0]        br_class,
    input  logic              br_tgt_ring0,
    input  logic [VA_W-1:0]   br_from,
    input  logic [VA_W-1:0]   br_to,
    input  logic              br_mispred,
    input  logic              br_in_tx,
    input  logic              br_abort,
    input  logic              pmi,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_from,
    output logic [WORD_W-1:0] rd_to
);

    logic [SEL_W-1:0]     sel;
    logic [IDX_W-1:0]     tos;
    logic                 suppress;
    logic                 rec;
    logic                 clr;
    logic [ADDR_KEEP-1:0] from_sx;
    logic [WORD_W-1:0]    from_word;
    logic [WORD_W-1:0]    to_word;

    assign from_sx   = ADDR_KEEP'($signed(br_from));
    assign from_word = {br_mispred, br_in_tx, br_abort, from_sx};
    assign to_word   = WORD_W'($signed(br_to));

    brr_filter u_filter (
        .sel       (sel),
        .cls       (br_class),
        .tgt_ring0 (br_tgt_ring0),
        .suppress  (suppress)
    );

    brr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pmi       (pmi),
        .br_valid  (br_valid),
        .suppress  (suppress),
        .sel       (sel),
        .tos       (tos),
        .rec       (rec),
        .clr       (clr),
        .reg_rdata (reg_rdata)
    );

    brr_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rec),
        .clr     (clr),
        .tos     (tos),
        .wr_from (from_word),
        .wr_to   (to_word),
        .rd_idx  (rd_idx),
        .rd_from (rd_from),
        .rd_to   (rd_to)
    );

    // R7: disabled recording never writes the stack
    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] == 1'b0 && reg_addr == RA_CTRL && br_valid) |-> !rec);

    // R5: a vetoed event is never recorded
    a_r5_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |-> !rec);

endmodule

// File: tb/branch_record_ring_bench.sv
`timescale 1ns/1ps
module branch_record_ring_bench;
    import brr_pkg::*;

    localparam int DEPTH = 16;
    localparam int VA    = 48;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 0;
    logic [2:0]    br_class = 0;
    logic          br_tgt_ring0 = 0;
    logic [VA-1:0] br_from = 0;
    logic [VA-1:0] br_to = 0;
    logic          br_mispred = 0, br_in_tx = 0, br_abort = 0;
    logic          pmi = 0;
    logic          reg_wr = 0;
    logic [2:0]    reg_addr = 0;
    logic [63:0]   reg_wdata = 0;
    logic [63:0]   reg_rdata;
    logic [IW-1:0] rd_idx = 0;
    logic [63:0]   rd_from, rd_to;

    always #10 clk = ~clk;

    branch_record_ring #(.DEPTH(DEPTH), .VA_W(VA)) u_branch_record_ring (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_class(br_class),
        .br_tgt_ring0(br_tgt_ring0), .br_from(br_from), .br_to(br_to),
        .br_mispred(br_mispred), .br_in_tx(br_in_tx), .br_abort(br_abort),
        .pmi(pmi), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rd_idx(rd_idx), .rd_from(rd_from), .rd_to(rd_to)
    );

    // reference model
    logic [63:0] fm [DEPTH];
    logic [63:0] tm [DEPTH];
    int          tos_m = 0;
    logic [8:0]  sel_m = 0;
    logic [1:0]  ctl_m = 0;
    bit          frz_m = 0;

    int    nchk = 0, nerr = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [63:0] mk_from(logic [VA-1:0] a, bit m, bit t, bit ab);
        longint s;
        s = longint'($signed(a));
        return {m, t, ab, s[60:0]};
    endfunction

    function automatic logic [63:0] exp_reg(int a);
        case (a)
            0: return 64'(sel_m);
            1: return 64'(ctl_m);
            2: return 64'(tos_m);
            3: return 64'(frz_m);
            default: return 64'd0;
        endcase
    endfunction

    task automatic compare_all();
        logic [IW-1:0] save_i;
        logic [2:0]    save_a;
        save_i = rd_idx;
        save_a = reg_addr;
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = IW'(i);
            #0.1;
            chk(cur_req, $sformatf("from[%0d]", i), rd_from, fm[(tos_m - i) & (DEPTH-1)]);
            chk(cur_req, $sformatf("to[%0d]", i),   rd_to,   tm[(tos_m - i) & (DEPTH-1)]);
        end
        for (int a = 0; a < 5; a++) begin
            reg_addr = 3'(a);
            #0.1;
            chk(cur_req, $sformatf("reg[%0d]", a), reg_rdata, exp_reg(a));
        end
        rd_idx   = save_i;
        reg_addr = save_a;
        #0.1;
    endtask

    task automatic tick();
        bit wt, wc, sup, rec, nfrz;
        int c;
        @(posedge clk);
        if (rst_n) begin
            wt   = reg_wr && reg_addr == 3'd2;
            wc   = reg_wr && reg_addr == 3'd4;
            c    = int'(br_class);
            sup  = ((c < 7) && sel_m[2+c]) || (br_tgt_ring0 ? sel_m[0] : sel_m[1]);
            rec  = br_valid && ctl_m[0] && !frz_m && !sup && !wt && !wc;
            nfrz = frz_m;
            if (reg_wr && reg_addr == 3'd3 && reg_wdata[0]) nfrz = 0;
            if (pmi && ctl_m[1]) nfrz = 1;
            if (reg_wr && reg_addr == 3'd0) sel_m = reg_wdata[8:0];
            if (reg_wr && reg_addr == 3'd1) ctl_m = reg_wdata[1:0];
            if (wc) for (int i = 0; i < DEPTH; i++) begin fm[i] = 0; tm[i] = 0; end
            if (wt) tos_m = int'(reg_wdata[IW-1:0]);
            else if (rec) begin
                tos_m = (tos_m + 1) % DEPTH;
                fm[tos_m] = mk_from(br_from, br_mispred, br_in_tx, br_abort);
                tm[tos_m] = 64'(longint'($signed(br_to)));
            end
            frz_m = nfrz;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic wreg(logic [2:0] a, logic [63:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic br(logic [2:0] c, bit r0, logic [VA-1:0] f, logic [VA-1:0] t,
                      bit m, bit tx, bit ab);
        br_valid = 1; br_class = c; br_tgt_ring0 = r0; br_from = f; br_to = t;
        br_mispred = m; br_in_tx = tx; br_abort = ab;
        tick();
        br_valid = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog R2: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        for (int i = 0; i < DEPTH; i++) begin fm[i] = 0; tm[i] = 0; end
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare_all();
        rst_n = 1;
        tick();

        cur_req = "R7";
        br(BR_COND, 0, 48'h1000, 48'h2000, 0, 0, 0);
        chk("R7", "tos while disabled", 64'(tos_m), 64'd0);

        cur_req = "R4";
        wreg(3'd1, 64'd1);
        br(BR_FAR, 0, 48'h8000_0000_1234, 48'h4000, 1, 0, 1);
        rd_idx = 0; #0.1;
        chk("R4", "from word", rd_from, 64'hBFFF_8000_0000_1234);
        chk("R4", "to word", rd_to, 64'h4000);
        br(BR_COND, 1, 48'h0000_0000_0ABC, 48'hFFFF_FFFF_F000, 0, 1, 0);
        rd_idx = 0; #0.1;
        chk("R4", "from word tx", rd_from, 64'h4000_0000_0000_0ABC);
        chk("R4", "to word neg", rd_to, 64'hFFFF_FFFF_FFFF_F000);

        cur_req = "R2";
        for (int i = 0; i < 20; i++)
            br(3'(i % 7), i[0], 48'(64'h100 * (i + 1)), 48'(64'h7000 + i), i[1], i[2], 0);
        chk("R2", "tos after wrap", 64'(tos_m), 64'((2 + 20) % DEPTH));
        cur_req = "R3";
        rd_idx = 1; #0.1;
        chk("R3", "second newest", rd_from[47:0], 48'(64'h100 * 19));

        cur_req = "R5";
        for (int c = 0; c < 7; c++) begin
            wreg(3'd0, 64'(1 << (2 + c)));
            t0 = tos_m;
            br(3'(c), 0, 48'h5555, 48'h6666, 0, 0, 0);
            chk("R5", "vetoed class keeps tos", 64'(tos_m), 64'(t0));
            br(3'((c + 1) % 7), 0, 48'h5557, 48'h6668, 0, 0, 0);
        end
        wreg(3'd0, 64'h1FC);
        br(BR_OTHER, 0, 48'h9999, 48'hAAAA, 0, 0, 0);

        cur_req = "R6";
        wreg(3'd0, 64'h1);
        br(BR_COND, 1, 48'h1111, 48'h2222, 0, 0, 0);
        br(BR_COND, 0, 48'h1113, 48'h2224, 0, 0, 0);
        wreg(3'd0, 64'h2);
        br(BR_COND, 0, 48'h1115, 48'h2226, 0, 0, 0);
        br(BR_COND, 1, 48'h1117, 48'h2228, 0, 0, 0);
        wreg(3'd0, 64'h0);

        cur_req = "R10";
        reg_wdata = 64'd5; reg_addr = 3'd2; reg_wr = 1;
        br(BR_COND, 0, 48'h3333, 48'h4444, 0, 0, 0);
        reg_wr = 0;
        chk("R10", "loaded tos", 64'(tos_m), 64'd5);
        br(BR_COND, 0, 48'h3335, 48'h4446, 0, 0, 0);

        cur_req = "R8";
        wreg(3'd1, 64'd3);
        t0 = tos_m;
        pmi = 1;
        br(BR_JMP_SAFE(), 0, 48'h7777, 48'h8888, 1, 1, 1);
        pmi = 0;
        chk("R8", "same-cycle branch kept", 64'(tos_m), 64'((t0 + 1) % DEPTH));
        br(BR_COND, 0, 48'h7779, 48'h888A, 0, 0, 0);
        chk("R8", "frozen blocks", 64'(tos_m), 64'((t0 + 1) % DEPTH));

        cur_req = "R9";
        wreg(3'd3, 64'd0);
        br(BR_COND, 0, 48'h777B, 48'h888C, 0, 0, 0);
        reg_wr = 1; reg_addr = 3'd3; reg_wdata = 64'd1; pmi = 1;
        tick();
        reg_wr = 0; pmi = 0;
        chk("R9", "pulse beats clear", 64'(frz_m), 64'd1);
        wreg(3'd3, 64'd1);
        br(BR_COND, 0, 48'h777D, 48'h888E, 0, 0, 0);
        wreg(3'd1, 64'd1);
        pmi = 1; tick(); pmi = 0;
        br(BR_COND, 0, 48'h777F, 48'h8890, 0, 0, 0);
        chk("R9", "unarmed pulse no freeze", 64'(frz_m), 64'd0);

        cur_req = "R11";
        t0 = tos_m;
        reg_wdata = 64'd0; reg_addr = 3'd4; reg_wr = 1;
        br(BR_COND, 0, 48'hABCD, 48'hDCBA, 0, 0, 0);
        reg_wr = 0;
        chk("R11", "tos kept on clear", 64'(tos_m), 64'(t0));

        cur_req = "R12";
        wreg(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_addr = 3'd0; #0.1;
        chk("R12", "select width", reg_rdata, 64'h1FF);
        wreg(3'd0, 64'd0);

        cur_req = "R2";
        wreg(3'd1, 64'd3);
        wreg(3'd0, 64'(3'b101) << 2);
        for (int n = 0; n < 400; n++) begin
            br_valid     = ($urandom % 3) != 0;
            br_class     = 3'($urandom);
            br_tgt_ring0 = 1'($urandom);
            br_from      = 48'({$urandom, $urandom});
            br_to        = 48'({$urandom, $urandom});
            br_mispred   = 1'($urandom);
            br_in_tx     = 1'($urandom);
            br_abort     = 1'($urandom);
            pmi          = ($urandom % 25) == 0;
            reg_wr       = ($urandom % 8) == 0;
            reg_addr     = 3'($urandom % 5);
            reg_wdata    = (reg_addr == 3'd1) ? 64'($urandom % 4 | 1) : 64'({$urandom, $urandom});
            rd_idx       = 0;
            tick();
        end
        reg_wr = 0; br_valid = 0; pmi = 0;
        tick();

        done = 1;
        summary();
        $finish;
    end

    function automatic logic [2:0] BR_JMP_SAFE();
        return BR_REL_JMP;
    endfunction

endmodule